// File: doc/BRIEF.md
# Entropy FIFO Collection Controller

This block gathers random bits from a single-bit sampling source and packs them into a small bank of 32-bit words that software reads over a plain register bus. Software programs a sampling divider, sets the generator enable, and then asks for a number of bits by writing a count into a fill register. The block takes one bit per sample tick and writes the bits into the word bank one after another. Each collected bit lowers the fill register by one, and software polls that register until it reads zero.

Ticks come from a divider that runs off the system clock. The bit source is an external input, so a physical noise cell or, in verification, a pseudo-random shift register can drive it. A post-processing select register is also provided. Writing zero to it requests raw output.

Top module: `entropy_fill_ctrl`

## Requirements
- R1: After reset, every mapped register (divider 0x00, control 0x20, post-processing 0x30, fill 0x50, words 0x80 to 0x9C) reads zero.
- R2: Control bit 31 is the generator enable and is the only control bit that reads back. While it is clear no tick occurs and the fill register holds its value.
- R3: A divider write keeps write-data bits 15:1 as a 15-bit field. A read returns that field shifted left by one, so bit 0 and bits 31:16 read zero.
- R4: While enabled, a sample tick occurs every 2×field clocks, or on every clock when the field is zero. A divider write or a cleared enable restarts the tick phase.
- R5: On each tick with a nonzero fill count, one source bit is stored and the fill register decrements by one. Once it reaches zero it stays at zero.
- R6: Bit k of a request (k = 0 for the first bit) is stored in word k/32 at bit position k mod 32. Word n reads at address 0x80 + 4n.
- R7: A fill write larger than 256 loads 256, and a 256-bit request fills all eight words.
- R8: A fill write, including one made during a collection, clears all words and restarts collection at word 0, bit 0. The write takes priority over a tick in the same cycle.
- R9: The post-processing register stores and reads back all 32 bits written.
- R10: Reads of unmapped or unaligned addresses return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from the current state |
| src_bit | input | 1 | Entropy bit sampled on each tick |

## Verification
Two cases are hard to reach from the ports. In one, a new fill write lands in the same cycle as a tick. In the other, the enable drops partway through a word, so the bit pointer must resume exactly where it stopped. The stimulus uses a divider of zero so that every enabled cycle is a tick, which makes a mid-collection rewrite collide with a tick. It also toggles the enable in the middle of a request. A cycle-accurate behavioural model in the bench predicts the addressed register every clock. The bench rotates its read address over the fill register and all eight words, so a misplaced bit is seen within a few cycles.

// File: rtl/efc_pkg.sv
package efc_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_DIV  = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h20;
    localparam logic [ADDR_W-1:0] ADDR_POST = 8'h30;
    localparam logic [ADDR_W-1:0] ADDR_FILL = 8'h50;
    localparam logic [ADDR_W-1:0] ADDR_FIFO = 8'h80;
    localparam int EN_BIT = 31;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIV,
        SEL_CTRL,
        SEL_POST,
        SEL_FILL,
        SEL_FIFO
    } reg_sel_e;
endpackage

// File: rtl/efc_tick_gen.sv
module efc_tick_gen #(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_field,
    input  logic             restart,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t cur_q, nxt_d;
    logic [CNT_W-1:0] period;

    always_comb begin
        nxt_d  = cur_q;
        period = (div_field == '0) ? CNT_W'(1) : {div_field, 1'b0};
        tick   = en && (cur_q.cnt == period - CNT_W'(1));
        if (restart || !en || tick) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/efc_bit_packer.sv
module efc_bit_packer #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          src_bit,
    input  logic                          load,
    input  logic [$clog2(WORDS*DATA_W):0] load_count,
    output logic [$clog2(WORDS*DATA_W):0] remaining,
    output logic [WORDS-1:0][DATA_W-1:0]  fifo_words
);
    localparam int BITS  = WORDS * DATA_W;
    localparam int POS_W = $clog2(BITS);
    localparam int CNT_W = POS_W + 1;
    localparam int BIT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [CNT_W-1:0]             remaining;
        logic [POS_W-1:0]             pos;
        logic [WORDS-1:0][DATA_W-1:0] fifo;
    } pack_state_t;

    pack_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.remaining = load_count;
            nxt_d.pos       = '0;
            nxt_d.fifo      = '0;
        end else if (tick && (cur_q.remaining != '0)) begin
            nxt_d.fifo[cur_q.pos[POS_W-1:BIT_W]][cur_q.pos[BIT_W-1:0]] = src_bit;
            nxt_d.pos       = cur_q.pos + POS_W'(1);
            nxt_d.remaining = cur_q.remaining - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign remaining  = cur_q.remaining;
    assign fifo_words = cur_q.fifo;
endmodule

// File: rtl/efc_regbus.sv
module efc_regbus
    import efc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int DIV_W  = 15,
    parameter int CNT_W  = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [CNT_W-1:0]             fill_count,
    input  logic [WORDS-1:0][DATA_W-1:0] fifo_words,
    output logic [DATA_W-1:0]            rdata,
    output logic [DIV_W-1:0]             div_field,
    output logic                         gen_en,
    output logic                         div_we,
    output logic                         fill_we,
    output logic [CNT_W-1:0]             fill_req
);
    localparam int BITS  = WORDS * DATA_W;
    localparam int IDX_W = $clog2(WORDS);
    localparam logic [ADDR_W-1:0] FIFO_SPAN = ADDR_W'(4 * WORDS);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              en;
        logic [DATA_W-1:0] post;
    } reg_state_t;

    reg_state_t       cur_q, nxt_d;
    reg_sel_e         sel;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] off;

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        off = addr - ADDR_FIFO;
        if (addr == ADDR_DIV) begin
            sel = SEL_DIV;
        end else if (addr == ADDR_CTRL) begin
            sel = SEL_CTRL;
        end else if (addr == ADDR_POST) begin
            sel = SEL_POST;
        end else if (addr == ADDR_FILL) begin
            sel = SEL_FILL;
        end else if ((addr >= ADDR_FIFO) && (off < FIFO_SPAN) && (off[1:0] == 2'b00)) begin
            sel = SEL_FIFO;
            idx = off[IDX_W+1:2];
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            case (sel)
                SEL_DIV:  nxt_d.div  = wdata[DIV_W:1];
                SEL_CTRL: nxt_d.en   = wdata[EN_BIT];
                SEL_POST: nxt_d.post = wdata;
                default:  ;
            endcase
        end
        div_we   = wr_en && (sel == SEL_DIV);
        fill_we  = wr_en && (sel == SEL_FILL);
        fill_req = (wdata > DATA_W'(BITS)) ? CNT_W'(BITS) : wdata[CNT_W-1:0];
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_DIV:  rdata = DATA_W'({cur_q.div, 1'b0});
            SEL_CTRL: rdata[EN_BIT] = cur_q.en;
            SEL_POST: rdata = cur_q.post;
            SEL_FILL: rdata = DATA_W'(fill_count);
            SEL_FIFO: rdata = fifo_words[idx];
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign div_field = cur_q.div;
    assign gen_en    = cur_q.en;
endmodule

// File: rtl/entropy_fill_ctrl.sv
module entropy_fill_ctrl #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int DIV_W  = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_en,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        src_bit
);
    localparam int BITS  = WORDS * DATA_W;
    localparam int CNT_W = $clog2(BITS) + 1;

    logic [DIV_W-1:0]             div_field_w;
    logic                         gen_en_w;
    logic                         div_we_w;
    logic                         fill_we_w;
    logic [CNT_W-1:0]             fill_req_w;
    logic [CNT_W-1:0]             remaining_w;
    logic [WORDS-1:0][DATA_W-1:0] fifo_w;
    logic                         tick_w;

    efc_regbus #(
        .DATA_W(DATA_W),
        .WORDS (WORDS),
        .DIV_W (DIV_W),
        .CNT_W (CNT_W)
    ) u_regbus (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .fill_count(remaining_w),
        .fifo_words(fifo_w),
        .rdata     (bus_rdata),
        .div_field (div_field_w),
        .gen_en    (gen_en_w),
        .div_we    (div_we_w),
        .fill_we   (fill_we_w),
        .fill_req  (fill_req_w)
    );

    efc_tick_gen #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (gen_en_w),
        .div_field(div_field_w),
        .restart  (div_we_w),
        .tick     (tick_w)
    );

    efc_bit_packer #(
        .DATA_W(DATA_W),
        .WORDS (WORDS)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .src_bit   (src_bit),
        .load      (fill_we_w),
        .load_count(fill_req_w),
        .remaining (remaining_w),
        .fifo_words(fifo_w)
    );
endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
    parameter int CNT_W = 9,
    parameter int BITS  = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic             tick,
    input logic             gen_en,
    input logic [CNT_W-1:0] remaining
);
    logic fill_wr;
    logic mapped;

    assign fill_wr = wr_en && (addr == 8'h50);
    assign mapped  = (addr == 8'h00) || (addr == 8'h20) || (addr == 8'h30) ||
                     (addr == 8'h50) ||
                     ((addr >= 8'h80) && (addr < 8'hA0) && (addr[1:0] == 2'b00));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= CNT_W'(BITS));

    p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_wr && (wdata > 32'(BITS))) |=> (remaining == CNT_W'(BITS)));

    p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en && !fill_wr) |=> $stable(remaining));

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (remaining != '0) && !fill_wr) |=> (remaining == $past(remaining) - CNT_W'(1)));

    p_div_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h00) |-> (rdata[0] == 1'b0 && rdata[31:16] == 16'h0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == 32'h0));
endmodule

bind entropy_fill_ctrl efc_checker #(
    .CNT_W(CNT_W),
    .BITS (BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .tick     (tick_w),
    .gen_en   (gen_en_w),
    .remaining(remaining_w)
);

// File: tb/entropy_fill_ctrl_test.sv
module entropy_fill_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        src_bit = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [15:0] lfsr = 16'hACE1;
    int unsigned m_fifo[8];
    int unsigned m_rem = 0, m_pos = 0, m_div = 0, m_cnt = 0;
    logic [31:0] m_post = 32'h0;
    bit m_en = 0;

    always #4 clk = ~clk;

    entropy_fill_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr_en(bus_wr_en),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .src_bit  (src_bit)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return 32'(m_div << 1);
        if (a == 8'h20) return {m_en, 31'h0};
        if (a == 8'h30) return m_post;
        if (a == 8'h50) return 32'(m_rem);
        if (a >= 8'h80 && a < 8'hA0 && a[1:0] == 2'b00) return m_fifo[(a - 8'h80) >> 2];
        return 32'h0;
    endfunction

    task automatic m_step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic b);
        int unsigned period = (m_div == 0) ? 1 : 2 * m_div;
        bit tk = m_en && (m_cnt == period - 1);
        bit fw = we && (a == 8'h50);
        m_cnt = ((we && a == 8'h00) || !m_en || tk) ? 0 : m_cnt + 1;
        if (fw) begin
            m_rem = (d > 256) ? 256 : d;
            m_pos = 0;
            foreach (m_fifo[i]) m_fifo[i] = 0;
        end else if (tk && m_rem > 0) begin
            if (b) m_fifo[m_pos / 32] |= (32'h1 << (m_pos % 32));
            else   m_fifo[m_pos / 32] &= ~(32'h1 << (m_pos % 32));
            m_pos++;
            m_rem--;
        end
        if (we) begin
            if (a == 8'h00) m_div = (d >> 1) & 32'h7FFF;
            if (a == 8'h20) m_en = d[31];
            if (a == 8'h30) m_post = d;
        end
    endtask

    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] exp;
        @(negedge clk);
        bus_wr_en = we;
        bus_addr  = a;
        bus_wdata = d;
        src_bit   = lfsr[0];
        #1;
        exp = m_read(a);
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", cur_req, a, bus_rdata, exp);
        end
        @(posedge clk);
        m_step(we, a, d, src_bit);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            if (i % 2 == 0) cyc(1'b0, 8'h50, 32'h0);
            else cyc(1'b0, 8'(8'h80 + 4 * ((i / 2) % 8)), 32'h0);
        end
    endtask

    task automatic sweep();
        cyc(1'b0, 8'h00, 32'h0);
        cyc(1'b0, 8'h20, 32'h0);
        cyc(1'b0, 8'h30, 32'h0);
        cyc(1'b0, 8'h50, 32'h0);
        for (int w = 0; w < 8; w++) cyc(1'b0, 8'(8'h80 + 4 * w), 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        foreach (m_fifo[i]) m_fifo[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        sweep();

        cur_req = "R3";
        cyc(1'b1, 8'h00, 32'hFFFF_FFFF);
        cyc(1'b0, 8'h00, 32'h0);
        cyc(1'b1, 8'h00, 32'h0000_0009);
        cyc(1'b0, 8'h00, 32'h0);
        cyc(1'b1, 8'h00, 32'h0);
        cyc(1'b0, 8'h00, 32'h0);

        cur_req = "R9";
        cyc(1'b1, 8'h30, 32'hA5A5_0001);
        cyc(1'b0, 8'h30, 32'h0);
        cyc(1'b1, 8'h30, 32'h0);
        cyc(1'b0, 8'h30, 32'h0);

        cur_req = "R2";
        cyc(1'b1, 8'h50, 32'd40);
        idle(20);
        cyc(1'b1, 8'h20, 32'hFFFF_FFFF);
        cyc(1'b0, 8'h20, 32'h0);

        cur_req = "R5";
        idle(50);

        cur_req = "R6";
        sweep();

        cur_req = "R4";
        cyc(1'b1, 8'h00, 32'h0000_0006);
        cyc(1'b1, 8'h50, 32'd5);
        idle(40);
        cyc(1'b1, 8'h00, 32'h0000_0004);
        cyc(1'b1, 8'h50, 32'd6);
        idle(30);

        cur_req = "R7";
        cyc(1'b1, 8'h00, 32'h0);
        cyc(1'b1, 8'h50, 32'd1000);
        idle(270);
        sweep();

        cur_req = "R8";
        cyc(1'b1, 8'h50, 32'd64);
        idle(21);
        cyc(1'b1, 8'h50, 32'd10);
        idle(16);
        sweep();

        cur_req = "R2";
        cyc(1'b1, 8'h50, 32'd30);
        idle(5);
        cyc(1'b1, 8'h20, 32'h7FFF_FFFF);
        idle(12);
        cyc(1'b1, 8'h20, 32'h8000_0000);
        idle(30);

        cur_req = "R10";
        cyc(1'b1, 8'h04, 32'hFFFF_FFFF);
        cyc(1'b1, 8'h60, 32'h1234_5678);
        cyc(1'b1, 8'hA0, 32'hFFFF_FFFF);
        cyc(1'b1, 8'h82, 32'hFFFF_FFFF);
        cyc(1'b1, 8'h31, 32'hFFFF_FFFF);
        cyc(1'b0, 8'h04, 32'h0);
        cyc(1'b0, 8'h82, 32'h0);
        cyc(1'b0, 8'hFC, 32'h0);
        sweep();

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule